// File: doc/BRIEF.md
# Side-band Isolation Shell

This block places a small peripheral core inside a shell, so that the core can be exercised through its APB slave port alone. The core has side-band signals that are not part of the bus: inputs that normally come from pins or from neighbouring logic, and outputs that normally go back to them. One control bit decides where these signals connect. When the bit is clear, the core talks to the system. When the bit is set, a register written over the bus drives every side-band input. Every side-band output is sampled into a register that software can read, and the outputs toward the system stay quiet. The core's behaviour then depends on bus traffic only.

The example core is a free-running tick counter. It advances on each clock while its run input is high. It raises a wrap flag in the cycle where an enabled step takes it from all-ones back to zero. The count can be loaded and read over the bus.

Top module: `sbiso_shell`

## Requirements
- R1: After a synchronous reset every register reads zero: control at offset 0x0, test input at 0x4, test output at 0x8 and count at 0xC. The shell therefore leaves reset in normal mode.
- R2: In normal mode the count rises by one, wrapping modulo 2^CNT_W, at every clock edge where `sys_en_i` is high. It holds where `sys_en_i` is low.
- R3: In normal mode `sys_ovf_o` is high, in the same cycle, exactly when the run input is high and the count is all-ones.
- R4: In test mode (control bit 0 set) the core's run input is bit 0 of the test-input register, and `sys_en_i` has no effect on the count.
- R5: In test mode `sys_ovf_o` stays at 0 whatever the core does.
- R6: Bit 0 of the test-output register holds the core's wrap flag from the previous clock, in both modes. Its upper bits read zero.
- R7: The test-output register is read only. A write to offset 0x8 changes no register.
- R8: A bus write to offset 0xC loads bits [CNT_W-1:0] into the count at that edge. The load takes priority over a step in the same cycle.
- R9: Only bit 0 of the control register and bit 0 of the test-input register are stored, and other bits read zero. An address with any bit set above bit 3 reads zero, and a write to it is ignored. Address bits [3:2] select the register.
- R10: Every transfer completes with no wait state: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| sys_en_i | input | 1 | System-side run request for the core |
| sys_ovf_o | output | 1 | System-side wrap flag of the core |

## Verification
The hardest case to reach is a wrap in test mode. The counter must sit at all-ones while the test-input bit is high and the system enable is driven the opposite way. Only then does the quiet output and the captured flag in the test-output register show the isolation. The bench reaches it by loading every count value over the bus in both modes, with the run source set just before each load. A value of all-ones with run high is therefore visited in each mode. A reference model in the bench follows each edge and predicts the count, the wrap pin and the one-cycle-late capture.

// File: rtl/sbiso_pkg.sv
package sbiso_pkg;

    localparam int DATA_W = 32;

    // register slot selected by address bits [3:2]
    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_TIN  = 2'd1,
        RS_TOUT = 2'd2,
        RS_CNT  = 2'd3
    } reg_slot_e;

    // one bus transfer as seen by the register block
    typedef struct packed {
        logic              sel;
        logic              en;
        logic              wr;
        logic              hit;
        reg_slot_e         slot;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    // side-band signals of the example core
    typedef struct packed {
        logic run;
    } core_in_t;

    typedef struct packed {
        logic wrap;
    } core_out_t;

    localparam int SB_IN_W  = $bits(core_in_t);
    localparam int SB_OUT_W = $bits(core_out_t);

    function automatic reg_slot_e slot_of(input logic [1:0] word_idx);
        return reg_slot_e'(word_idx);
    endfunction

endpackage

// File: rtl/sbiso_tick_core.sv
module sbiso_tick_core
    import sbiso_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  core_in_t         sb_in,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count,
    output core_out_t        sb_out
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (sb_in.run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count       = cnt_q;
    assign sb_out.wrap = sb_in.run && (cnt_q == TOP);

endmodule

// File: rtl/sbiso_mux.sv
module sbiso_mux #(
    parameter int IN_W  = 1,
    parameter int OUT_W = 1
) (
    input  logic             test_mode,
    input  logic [IN_W-1:0]  sys_in,
    input  logic [IN_W-1:0]  tst_in,
    output logic [IN_W-1:0]  core_in,
    input  logic [OUT_W-1:0] core_out,
    output logic [OUT_W-1:0] sys_out
);
    for (genvar i = 0; i < IN_W; i++) begin : g_in
        assign core_in[i] = test_mode ? tst_in[i] : sys_in[i];
    end

    for (genvar j = 0; j < OUT_W; j++) begin : g_out
        assign sys_out[j] = test_mode ? 1'b0 : core_out[j];
    end

endmodule

// File: rtl/sbiso_regs.sv
module sbiso_regs
    import sbiso_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int IN_W  = 1,
    parameter int OUT_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [OUT_W-1:0]  core_out,
    output logic              test_mode,
    output logic [IN_W-1:0]   tin,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              ctrl_q;
    logic [IN_W-1:0]   tin_q;
    logic [OUT_W-1:0]  tout_q;
    logic              wr_acc;

    assign wr_acc = op.sel && op.en && op.wr && op.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
            tin_q  <= '0;
            tout_q <= '0;
        end else begin
            tout_q <= core_out;
            if (wr_acc) begin
                case (op.slot)
                    RS_CTRL: ctrl_q <= op.wdata[0];
                    RS_TIN:  tin_q  <= op.wdata[IN_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign test_mode = ctrl_q;
    assign tin       = tin_q;
    assign cnt_wr    = wr_acc && (op.slot == RS_CNT);
    assign cnt_wdata = op.wdata[CNT_W-1:0];

    always_comb begin
        rdata = '0;
        if (op.sel && !op.wr && op.hit) begin
            case (op.slot)
                RS_CTRL: rdata[0]         = ctrl_q;
                RS_TIN:  rdata[IN_W-1:0]  = tin_q;
                RS_TOUT: rdata[OUT_W-1:0] = tout_q;
                RS_CNT:  rdata[CNT_W-1:0] = cnt_val;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sbiso_shell.sv
module sbiso_shell
    import sbiso_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              pclk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              sys_en_i,
    output logic              sys_ovf_o
);
    bus_op_t               op;
    logic                  test_mode;
    logic [SB_IN_W-1:0]    tin;
    logic [SB_IN_W-1:0]    core_in_v;
    logic [SB_OUT_W-1:0]   core_out_v;
    logic [SB_OUT_W-1:0]   sys_out_v;
    logic                  cnt_wr;
    logic [CNT_W-1:0]      cnt_wdata;
    logic [CNT_W-1:0]      cnt_val;
    core_in_t              c_in;
    core_out_t             c_out;

    always_comb begin
        op.sel   = psel;
        op.en    = penable;
        op.wr    = pwrite;
        op.hit   = ((paddr >> 4) == '0);
        op.slot  = slot_of(paddr[3:2]);
        op.wdata = pwdata;
    end

    sbiso_regs #(.CNT_W(CNT_W), .IN_W(SB_IN_W), .OUT_W(SB_OUT_W)) u_regs (
        .clk       (pclk),
        .rst       (rst),
        .op        (op),
        .cnt_val   (cnt_val),
        .core_out  (core_out_v),
        .test_mode (test_mode),
        .tin       (tin),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rdata     (prdata)
    );

    sbiso_mux #(.IN_W(SB_IN_W), .OUT_W(SB_OUT_W)) u_mux (
        .test_mode (test_mode),
        .sys_in    (sys_en_i),
        .tst_in    (tin),
        .core_in   (core_in_v),
        .core_out  (core_out_v),
        .sys_out   (sys_out_v)
    );

    assign c_in       = core_in_t'(core_in_v);
    assign core_out_v = SB_OUT_W'(c_out);

    sbiso_tick_core #(.CNT_W(CNT_W)) u_core (
        .clk    (pclk),
        .rst    (rst),
        .sb_in  (c_in),
        .ld     (cnt_wr),
        .ld_val (cnt_wdata),
        .count  (cnt_val),
        .sb_out (c_out)
    );

    assign sys_ovf_o = sys_out_v[0];
    assign pready    = 1'b1;
    assign pslverr   = 1'b0;

endmodule

// File: rtl/sbiso_chk.sv
module sbiso_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              sys_en_i,
    input logic              sys_ovf_o,
    input logic              test_mode,
    input logic              core_run,
    input logic              core_wrap,
    input logic [CNT_W-1:0]  cnt_val
);
    logic past_ok;
    logic cnt_load;
    logic tout_read;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign cnt_load  = psel && penable && pwrite  && (paddr == ADDR_W'(12));
    assign tout_read = psel && penable && !pwrite && (paddr == ADDR_W'(8));

    // R10
    bus_resp_chk: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> !sys_ovf_o);

    // R3
    pin_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (sys_ovf_o == (sys_en_i && (&cnt_val))));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (cnt_val == $past(pwdata[CNT_W-1:0])));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_load && core_run) |=> (cnt_val == $past(cnt_val) + 1'b1));

    // R6
    tout_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && tout_read) |-> (prdata[0] == $past(core_wrap)));

endmodule

bind sbiso_shell sbiso_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (pclk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .sys_en_i  (sys_en_i),
    .sys_ovf_o (sys_ovf_o),
    .test_mode (test_mode),
    .core_run  (core_in_v[0]),
    .core_wrap (core_out_v[0]),
    .cnt_val   (cnt_val)
);

// File: tb/tb_sbiso_shell.sv
module tb_sbiso_shell;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic          sys_en = 1'b0;
    logic          sys_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbiso_shell #(.ADDR_W(AW), .CNT_W(8)) dut (
        .pclk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .sys_en_i(sys_en), .sys_ovf_o(sys_ovf)
    );

    // reference model built from the requirements
    logic       m_test, m_tin, m_tout;
    logic [7:0] m_cnt;

    function automatic logic m_run();
        return m_test ? m_tin : sys_en;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_test <= 1'b0; m_tin <= 1'b0; m_tout <= 1'b0; m_cnt <= 8'd0;
        end else begin
            automatic logic wr = psel && penable && pwrite && ((paddr >> 4) == 0);
            automatic logic run = m_run();
            m_tout <= run && (m_cnt == 8'hFF);
            if (wr && paddr[3:2] == 2'd3) m_cnt <= pwdata[7:0];
            else if (run)                 m_cnt <= m_cnt + 8'd1;
            if (wr && paddr[3:2] == 2'd0) m_test <= pwdata[0];
            if (wr && paddr[3:2] == 2'd1) m_tin  <= pwdata[0];
        end
    end

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        if ((a >> 4) != 0) return 32'd0;
        case (a[3:2])
            2'd0: return {31'd0, m_test};
            2'd1: return {31'd0, m_tin};
            2'd2: return {31'd0, m_tout};
            default: return {24'd0, m_cnt};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #(CLK_PERIOD/4);
        chk(tag, prdata, exp_read(a));
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    // pin-level checks every cycle
    always begin
        @(negedge clk); #1;
        if (live && !rst) begin
            if (m_test) chk("R5", {31'd0, sys_ovf}, 32'd0);
            else        chk("R3", {31'd0, sys_ovf}, {31'd0, m_run() && (m_cnt == 8'hFF)});
            chk("R10", {30'd0, pready, pslverr}, 32'd2);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R1 reset state
        bus_rd(8'h00, "R1");
        bus_rd(8'h04, "R1");
        bus_rd(8'h08, "R1");
        bus_rd(8'h0C, "R1");

        // R9 only bit 0 of control stored, unmapped space
        bus_wr(8'h00, 32'hFFFF_FFFE);
        bus_rd(8'h00, "R9");
        bus_wr(8'h14, 32'h0000_0001);
        bus_rd(8'h00, "R9");
        bus_rd(8'h1C, "R9");
        bus_wr(8'h04, 32'hFFFF_FFFE);
        bus_rd(8'h04, "R9");

        // R7 test output is read only
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_rd(8'h08, "R7");

        // normal-mode sweep: R2, R8, R6
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); sys_en = v[0] ^ v[3];
            bus_wr(8'h0C, v);
            bus_rd(8'h0C, "R2");
            bus_rd(8'h08, "R6");
        end
        sys_en = 1'b1;
        bus_wr(8'h0C, 32'h0000_00FF);
        bus_rd(8'h0C, "R8");

        // enter test mode, system enable driven against the test bit
        bus_wr(8'h00, 32'h1);
        bus_rd(8'h00, "R9");
        for (int v = 0; v < 256; v++) begin
            bus_wr(8'h04, {31'd0, v[0]});
            @(negedge clk); sys_en = ~v[0];
            bus_wr(8'h0C, v);
            bus_rd(8'h0C, "R4");
            bus_rd(8'h08, "R6");
        end

        // wrap inside test mode: pin quiet, capture visible
        bus_wr(8'h04, 32'h1);
        @(negedge clk); sys_en = 1'b0;
        bus_wr(8'h0C, 32'hFFFF_FFFE);
        bus_rd(8'h08, "R6");
        bus_rd(8'h08, "R6");
        @(negedge clk); #1;
        chk("R5", {31'd0, sys_ovf}, 32'd0);

        // leave test mode
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, "R9");
        @(negedge clk); sys_en = 1'b1;
        bus_wr(8'h0C, 32'hFE);
        bus_rd(8'h0C, "R2");
        bus_rd(8'h08, "R6");

        repeat (2) @(negedge clk);
        live = 1'b0;
        summary();
        $finish;
    end

endmodule